// File: doc/BRIEF.md
# FSK Character Deframer with Centred Data Clock

This block sits behind a 1200 baud FSK demodulator. It watches the recovered mark/space stream and finds each asynchronous ten-bit character in it. It then drives a three-wire output toward a host:

- the live data line, passed through;
- a data clock that pulses once in the middle of every data bit;
- an active-low end-of-word strobe.

The data line is not converted into a parallel byte. A host shifts in the eight data bits itself on the rising edges of the data clock, and it uses the end-of-word strobe as its interrupt.

Bit timing comes from a fractional phase accumulator. The accumulator turns the system clock into sixteen ticks per bit at the configured baud rate. A start bit is recognised on a mark-to-space edge and confirmed again at its middle. Data bits are clocked at their centres, and the stop bit is checked before the strobe is issued.

A carrier-detect input blanks the whole interface while no carrier is present. A power-down input parks the data and clock lines high and releases the strobe. The strobe is modelled as an output-enable plus a value, standing in for an open-drain pad.

Top module: `fskd_deframer`

## Requirements
- R1: After reset, with carrier present and power-down low, dataOut is 1, dataClk is 0, wordEndN is 1 and wordEndOe is 1.
- R2: While carrier is present and power-down is low, dataOut equals demodBit delayed by exactly two system clocks.
- R3: A fractional accumulator adds BAUD*OVS to a phase each system clock and emits a tick whenever the phase reaches SYS_HZ. That gives OVS (16) ticks per bit period, so a half-bit pulse lasts OVS/2 ticks.
- R4: A character is one start bit (0), eight data bits least significant first, and one stop bit (1). Mark is 1 and space is 0. Exactly eight dataClk rising edges are produced per character, each near the centre of one data bit, so sampling dataOut on them returns the data byte in order.
- R5: Each dataClk pulse stays high for exactly OVS/2 ticks. No rising edge of dataClk falls inside a start or stop bit.
- R6: When the stop bit samples as mark at its centre, wordEndN goes low for exactly OVS/2 ticks and then returns high.
- R7: A character only begins on a mark-to-space transition. If the line is back at mark at the middle of the start bit, the character is dropped with no dataClk pulse and no word-end pulse.
- R8: If the stop bit samples as space, no word-end pulse is issued. The block then waits for mark before it accepts the next start edge.
- R9: While carrierOn is low, dataOut is held at 1 and neither dataClk pulses nor word-end pulses appear.
- R10: While powerDown is high, dataOut and dataClk are 1, wordEndN is 1 and wordEndOe is 0, whatever demodBit does.
- R11: Characters sent about 1.6 % slower or faster than nominal (a bit length of 65 or 63 clocks where 64 is nominal) are framed and clocked correctly.
- R12: Characters sent back to back, with the next start edge at the end of the previous stop bit, are each framed correctly with their own word-end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that feeds the bit timebase |
| rstN | input | 1 | Asynchronous active-low reset |
| demodBit | input | 1 | Demodulated line state, 1 = mark, 0 = space |
| carrierOn | input | 1 | High while a carrier is present; low blanks the interface |
| powerDown | input | 1 | High parks the outputs and halts framing |
| dataOut | output | 1 | Pass-through of the demodulated stream (1 when blanked) |
| dataClk | output | 1 | Rising edge at the centre of each data bit |
| wordEndN | output | 1 | Active-low end-of-character strobe, half a bit wide |
| wordEndOe | output | 1 | Drive enable of the strobe; 0 means released |

## Verification
The end of one character's word-end pulse and the start-edge detection of the next character can land on the same tick. The pulse is timed in the datapath, while the frame search is in the control unit. Back-to-back characters with no idle mark between stop and start provoke this, at both nominal and skewed bit lengths. The bench judges each case by checking that every word-end pulse keeps its full 32-clock width and that the following character still yields eight centred clocks and the right byte.

// File: rtl/fskd_pkg.sv
package fskd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP
  } frameState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic quiet;    // interface blanked (no carrier or powered down)
    logic clkRise;  // raise the data clock now
    logic wordEnd;  // start the end-of-word strobe now
  } strobe_t;

endpackage

// File: rtl/fskd_timebase.sv
module fskd_timebase #(
  parameter int unsigned SYS_HZ  = 3579545,
  parameter int unsigned TICK_HZ = 19200
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int ACC_W = $clog2(SYS_HZ + TICK_HZ) + 1;

  logic [ACC_W-1:0] phase;
  logic [ACC_W-1:0] phaseNext;

  always_comb phaseNext = phase + ACC_W'(TICK_HZ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      tick  <= 1'b0;
    end else if (phaseNext >= ACC_W'(SYS_HZ)) begin
      phase <= phaseNext - ACC_W'(SYS_HZ);
      tick  <= 1'b1;
    end else begin
      phase <= phaseNext;
      tick  <= 1'b0;
    end
  end

  generate
    if (2 * TICK_HZ <= SYS_HZ) begin : g_gapChk
      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/fskd_ctrl.sv
module fskd_ctrl
  import fskd_pkg::*;
#(
  parameter int unsigned OVS       = 16,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    rxBit,
  input  logic    carrierOn,
  input  logic    powerDown,
  output strobe_t strobe
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  frameState_t      state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [IDX_W-1:0] idx, idxNext;
  logic             prevSample;
  logic             quiet;
  logic             riseNow;
  logic             endNow;

  assign quiet = powerDown | ~carrierOn;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    idxNext   = idx;
    riseNow   = 1'b0;
    endNow    = 1'b0;
    if (tick) begin
      unique case (state)
        ST_HUNT: begin
          if (prevSample && !rxBit) begin
            stateNext = ST_START;
            cntNext   = '0;
          end
        end
        ST_START: begin
          if (cnt == MID_CNT) begin
            if (rxBit) begin
              stateNext = ST_HUNT;
            end else begin
              stateNext = ST_DATA;
              cntNext   = '0;
              idxNext   = '0;
            end
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == LAST_CNT) begin
            riseNow = 1'b1;
            cntNext = '0;
            if (idx == LAST_IDX) stateNext = ST_STOP;
            else                 idxNext   = idx + 1'b1;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == LAST_CNT) begin
            endNow    = rxBit;
            stateNext = ST_HUNT;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        default: stateNext = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_HUNT;
      cnt        <= '0;
      idx        <= '0;
      prevSample <= 1'b1;
    end else if (quiet) begin
      state      <= ST_HUNT;
      cnt        <= '0;
      idx        <= '0;
      prevSample <= 1'b1;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      idx   <= idxNext;
      if (tick) prevSample <= rxBit;
    end
  end

  always_comb begin
    strobe.quiet   = quiet;
    strobe.clkRise = riseNow & ~quiet;
    strobe.wordEnd = endNow & ~quiet;
  end

endmodule

// File: rtl/fskd_datapath.sv
module fskd_datapath
  import fskd_pkg::*;
#(
  parameter int unsigned OVS       = 16,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    demodBit,
  input  logic    powerDown,
  input  strobe_t strobe,
  output logic    rxBit,
  output logic    dataOut,
  output logic    dataClk,
  output logic    wordEndN,
  output logic    wordEndOe
);
  localparam int HALF  = OVS / 2;
  localparam int HC_W  = $clog2(HALF) + 1;
  localparam int IDX_W = $clog2(DATA_BITS + 1);

  logic [1:0] syncReg;
  logic [1:0] pulseStart;
  logic [1:0] pulseOn;
  logic       clkOn;
  logic       weOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= 2'b11;
    else       syncReg <= {syncReg[0], demodBit};
  end

  assign rxBit      = syncReg[1];
  assign pulseStart = {strobe.wordEnd, strobe.clkRise};

  // channel 0: data clock, channel 1: end-of-word strobe
  for (genvar g = 0; g < 2; g++) begin : g_pulse
    logic            on;
    logic [HC_W-1:0] width;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        on    <= 1'b0;
        width <= '0;
      end else if (strobe.quiet) begin
        on    <= 1'b0;
        width <= '0;
      end else if (pulseStart[g]) begin
        on    <= 1'b1;
        width <= '0;
      end else if (tick && on) begin
        if (width == HC_W'(HALF - 1)) on <= 1'b0;
        else                          width <= width + 1'b1;
      end
    end
    assign pulseOn[g] = on;
  end

  assign clkOn     = pulseOn[0];
  assign weOn      = pulseOn[1];
  assign dataOut   = strobe.quiet ? 1'b1 : rxBit;
  assign dataClk   = powerDown | clkOn;
  assign wordEndN  = ~(weOn & ~powerDown);
  assign wordEndOe = ~powerDown;

  // count of clock strobes in the current character, for checking only
  logic [IDX_W-1:0] riseCount;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                riseCount <= '0;
    else if (strobe.quiet || strobe.wordEnd)  riseCount <= '0;
    else if (strobe.clkRise)
      riseCount <= (riseCount == IDX_W'(DATA_BITS)) ? IDX_W'(1) : riseCount + 1'b1;
  end

  // R4
  eight_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wordEnd |-> riseCount == IDX_W'(DATA_BITS));

  // R3
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clkRise |-> tick);

  // R8
  stop_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wordEnd |-> rxBit);

  // R5
  pulse_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOn) |-> !weOn);

  // R10
  pd_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (!clkOn && !weOn));

endmodule

// File: rtl/fskd_deframer.sv
module fskd_deframer
  import fskd_pkg::*;
#(
  parameter int unsigned SYS_HZ    = 3579545,
  parameter int unsigned BAUD      = 1200,
  parameter int unsigned OVS       = 16,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic demodBit,
  input  logic carrierOn,
  input  logic powerDown,
  output logic dataOut,
  output logic dataClk,
  output logic wordEndN,
  output logic wordEndOe
);
  localparam int unsigned TICK_HZ = BAUD * OVS;

  logic    tick;
  logic    rxBit;
  strobe_t strobe;

  fskd_timebase #(
    .SYS_HZ (SYS_HZ),
    .TICK_HZ(TICK_HZ)
  ) u_timebase (
    .clk (clk),
    .rstN(rstN),
    .tick(tick)
  );

  fskd_ctrl #(
    .OVS      (OVS),
    .DATA_BITS(DATA_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .rxBit    (rxBit),
    .carrierOn(carrierOn),
    .powerDown(powerDown),
    .strobe   (strobe)
  );

  fskd_datapath #(
    .OVS      (OVS),
    .DATA_BITS(DATA_BITS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .demodBit (demodBit),
    .powerDown(powerDown),
    .strobe   (strobe),
    .rxBit    (rxBit),
    .dataOut  (dataOut),
    .dataClk  (dataClk),
    .wordEndN (wordEndN),
    .wordEndOe(wordEndOe)
  );

endmodule

// File: tb/fskd_deframer_bench.sv
`timescale 1ns/1ps
module fskd_deframer_bench;

  localparam int NOM = 64;   // clocks per bit with SYS_HZ=76800, 16 ticks of 4 clocks
  localparam int HALF_CLKS = 32;

  typedef struct {
    logic [7:0] data;
    bit         expectWe;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic demodBit = 1'b1;
  logic carrierOn = 1'b1;
  logic powerDown = 1'b0;
  logic dataOut, dataClk, wordEndN, wordEndOe;

  int checks = 0;
  int fails = 0;
  int riseTotal = 0;
  int weTotal = 0;
  bit ended = 1'b0;
  bit monBusy = 1'b0;
  item_t expQ[$];

  always #5 clk = ~clk;

  fskd_deframer #(
    .SYS_HZ   (76800),
    .BAUD     (1200),
    .OVS      (16),
    .DATA_BITS(8)
  ) u_fskd_deframer (
    .clk      (clk),
    .rstN     (rstN),
    .demodBit (demodBit),
    .carrierOn(carrierOn),
    .powerDown(powerDown),
    .dataOut  (dataOut),
    .dataClk  (dataClk),
    .wordEndN (wordEndN),
    .wordEndOe(wordEndOe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic endRun();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // driver: call just after a falling clock edge
  task automatic sendChar(input logic [7:0] d, input bit stopVal, input int bitClks,
                          input bit push, input bit expWe, input bit checkQuiet);
    logic b;
    if (push) expQ.push_back('{d, expWe});
    for (int i = 0; i < 10; i++) begin
      if (i == 0)      b = 1'b0;
      else if (i == 9) b = stopVal;
      else             b = d[i-1];
      demodBit = b;
      for (int k = 0; k < bitClks; k++) begin
        @(negedge clk);
        if (checkQuiet && k == bitClks / 2)
          check(dataOut === 1'b1, "R9 dataOut held high without carrier", int'(dataOut), 1);
      end
    end
    demodBit = 1'b1;
  endtask

  task automatic idle(input int n);
    demodBit = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    bit prevClk;
    bit prevWe;
    int highLen;
    int lowLen;
    int bitsGot;
    int waitWe;
    bit haveCur;
    logic [7:0] got;
    item_t cur;
    prevClk = 1'b0; prevWe = 1'b1; highLen = 0; lowLen = 0;
    bitsGot = 0; waitWe = 0; haveCur = 1'b0; got = '0;
    cur = '{8'h00, 1'b0};
    forever begin
      @(negedge clk);
      monBusy = (bitsGot != 0) || (waitWe != 0);
      if (!rstN || powerDown) begin
        prevClk = dataClk; prevWe = wordEndN; highLen = 0; lowLen = 0;
        continue;
      end
      if (dataClk && !prevClk) begin
        riseTotal++;
        highLen = 1;
        if (bitsGot == 0 && waitWe == 0) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R7 R9 clock pulse with no character expected", 1, 0);
          end else begin
            cur = expQ.pop_front();
            haveCur = 1'b1;
            got = '0;
            got[0] = dataOut;
            bitsGot = 1;
          end
        end else if (haveCur && bitsGot < 8) begin
          got[bitsGot] = dataOut;
          bitsGot++;
          if (bitsGot == 8) waitWe = 100;
        end else begin
          check(1'b0, "R4 more than eight clock pulses in a character", bitsGot + 1, 8);
        end
      end else if (dataClk) begin
        highLen++;
      end else if (prevClk && highLen > 0) begin
        check(highLen == HALF_CLKS, "R3 R5 data clock high width", highLen, HALF_CLKS);
        highLen = 0;
      end

      if (!wordEndN && prevWe) begin
        weTotal++;
        lowLen = 1;
        if (waitWe > 0) begin
          check(cur.expectWe, "R6 R8 word-end pulse presence", 1, int'(cur.expectWe));
          check(got == cur.data, "R4 byte sampled on data clock", int'(got), int'(cur.data));
          bitsGot = 0; waitWe = 0; haveCur = 1'b0;
        end else begin
          check(1'b0, "R6 word-end pulse outside a character", 1, 0);
        end
      end else if (!wordEndN) begin
        lowLen++;
      end else if (!prevWe && lowLen > 0) begin
        check(lowLen == HALF_CLKS, "R6 word-end low width", lowLen, HALF_CLKS);
        lowLen = 0;
      end

      if (waitWe > 0) begin
        waitWe--;
        if (waitWe == 0) begin
          check(!cur.expectWe, "R6 R8 word-end pulse presence", 0, int'(cur.expectWe));
          check(got == cur.data, "R4 byte sampled on data clock", int'(got), int'(cur.data));
          bitsGot = 0; haveCur = 1'b0;
        end
      end
      prevClk = dataClk;
      prevWe = wordEndN;
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    endRun();
  end

  initial begin
    int riseSnap;
    int weSnap;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(dataOut === 1'b1, "R1 dataOut in reset", int'(dataOut), 1);
    check(dataClk === 1'b0, "R1 dataClk in reset", int'(dataClk), 0);
    check(wordEndN === 1'b1, "R1 wordEndN in reset", int'(wordEndN), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(wordEndOe === 1'b1, "R1 wordEndOe after reset", int'(wordEndOe), 1);
    idle(100);

    // R2 two-clock pass-through, then R7 short space dropped
    riseSnap = riseTotal; weSnap = weTotal;
    demodBit = 1'b0;
    @(negedge clk);
    check(dataOut === 1'b1, "R2 dataOut after one clock", int'(dataOut), 1);
    @(negedge clk);
    check(dataOut === 1'b0, "R2 dataOut after two clocks", int'(dataOut), 0);
    repeat (18) @(negedge clk);
    idle(800);
    check(riseTotal == riseSnap, "R7 no clock after short space", riseTotal - riseSnap, 0);
    check(weTotal == weSnap, "R7 no word end after short space", weTotal - weSnap, 0);

    // R4 R5 R6 nominal characters with idle gaps
    sendChar(8'h55, 1'b1, NOM, 1'b1, 1'b1, 1'b0); idle(100);
    sendChar(8'hA3, 1'b1, NOM, 1'b1, 1'b1, 1'b0); idle(100);
    sendChar(8'h00, 1'b1, NOM, 1'b1, 1'b1, 1'b0); idle(100);
    sendChar(8'hFF, 1'b1, NOM, 1'b1, 1'b1, 1'b0); idle(100);

    // R12 back to back
    sendChar(8'h3C, 1'b1, NOM, 1'b1, 1'b1, 1'b0);
    sendChar(8'hC1, 1'b1, NOM, 1'b1, 1'b1, 1'b0);
    sendChar(8'h81, 1'b1, NOM, 1'b1, 1'b1, 1'b0);
    idle(200);

    // R11 skewed bit lengths, also back to back
    sendChar(8'h96, 1'b1, NOM - 1, 1'b1, 1'b1, 1'b0);
    sendChar(8'h4E, 1'b1, NOM - 1, 1'b1, 1'b1, 1'b0);
    idle(150);
    sendChar(8'h69, 1'b1, NOM + 1, 1'b1, 1'b1, 1'b0);
    sendChar(8'hE1, 1'b1, NOM + 1, 1'b1, 1'b1, 1'b0);
    idle(200);

    // R8 stop bit at space: eight clocks, no word end, then recovery
    sendChar(8'h5A, 1'b0, NOM, 1'b1, 1'b0, 1'b0);
    idle(300);
    sendChar(8'h24, 1'b1, NOM, 1'b1, 1'b1, 1'b0);
    idle(200);

    // R9 carrier absent
    carrierOn = 1'b0;
    riseSnap = riseTotal; weSnap = weTotal;
    idle(10);
    sendChar(8'h00, 1'b1, NOM, 1'b0, 1'b0, 1'b1);
    idle(200);
    check(riseTotal == riseSnap, "R9 no clock without carrier", riseTotal - riseSnap, 0);
    check(weTotal == weSnap, "R9 no word end without carrier", weTotal - weSnap, 0);
    carrierOn = 1'b1;
    idle(100);

    // R10 power-down
    powerDown = 1'b1;
    @(negedge clk);
    check(dataOut === 1'b1, "R10 dataOut parked", int'(dataOut), 1);
    check(dataClk === 1'b1, "R10 dataClk parked", int'(dataClk), 1);
    check(wordEndN === 1'b1, "R10 wordEndN released", int'(wordEndN), 1);
    check(wordEndOe === 1'b0, "R10 wordEndOe released", int'(wordEndOe), 0);
    sendChar(8'h0F, 1'b1, NOM, 1'b0, 1'b0, 1'b0);
    check(dataClk === 1'b1, "R10 dataClk still parked", int'(dataClk), 1);
    check(wordEndOe === 1'b0, "R10 wordEndOe still released", int'(wordEndOe), 0);
    idle(20);
    powerDown = 1'b0;
    idle(100);
    check(dataClk === 1'b0, "R10 dataClk idle after wake", int'(dataClk), 0);
    check(wordEndOe === 1'b1, "R10 wordEndOe after wake", int'(wordEndOe), 1);
    sendChar(8'h7E, 1'b1, NOM, 1'b1, 1'b1, 1'b0);
    idle(200);

    while (expQ.size() != 0 || monBusy) @(negedge clk);
    idle(50);
    endRun();
  end

endmodule